// File: doc/BRIEF.md
# Dimming Half-Bridge PWM Sequencer

This block drives the two gate commands of a half-bridge lamp inverter. A free-running period counter sets a fixed switching frequency. The nominal setting is 1515 clocks at 50 MHz, which gives about 33 kHz. The high-side command is on for a duty count D and the low-side command is on for the rest of the period. A programmable dead time holds both commands low at each hand-over.

The duty count follows a fixed schedule. First comes a silent start-up delay. A linear soft start then raises D from zero to half the period. D holds at half for a full-power phase, which cannot be shorter than a warm-up minimum. A rate-limited linear ramp then brings D down to a reduced level, and D stays there until reset.

All time intervals are counted in seconds of a prescaled tick. A bench can therefore compress hours into a few thousand clocks by shrinking the prescaler. The current phase is exposed as a 3-bit code.

Top module: `dim_pwm_seq`

## Requirements
- R1: While rst_ni is low, state_o is 0 and both gate outputs are low.
- R2: For DELAY_S*TICK_DIV clocks after reset release, state_o is 0 and both gate outputs stay low.
- R3: With period count c (0..PERIOD_CYC-1), the latched duty d and the latched dead time t:
  - hs_o is high exactly for t <= c < d.
  - ls_o is high exactly for c >= d+t.
  - hs_o and ls_o are never high together.
- R4: The duty, the dead time and the output enable are sampled only at count PERIOD_CYC-1, so they take effect from count 0 of the next period.
- R5: Soft start lasts T = max(soft_s_i,1)*TICK_DIV clocks. After n clocks in it, the duty is floor(HALF*n/T), where HALF = floor(PERIOD_CYC/2).
- R6: The full-power phase holds the duty at HALF for max(hold_s_i, MIN_HOLD_S)*TICK_DIV clocks, so a shorter setting is extended to the warm-up minimum.
- R7: The ramp down lasts T = max(ramp_s_i, MIN_RAMP_S)*TICK_DIV clocks. After n clocks in it, the duty is HALF - floor(S*n/T), where S = HALF - target. The duty never rises during the ramp and falls by at most one count per clock.
- R8: The reduced target is red_duty_i clamped into [floor(PERIOD_CYC/5), HALF].
- R9: Once reduced power is reached, the duty stays at the target and the state never leaves the reduced phase until reset.
- R10: The state_o codes are 0 start-up delay, 1 soft start, 2 full power, 3 ramp down and 4 reduced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| soft_s_i | input | SEC_W | Soft-start length in seconds (0 treated as 1) |
| hold_s_i | input | SEC_W | Full-power hold length in seconds |
| ramp_s_i | input | SEC_W | Ramp-down length in seconds |
| red_duty_i | input | DUTY_W | Reduced-power duty in clock counts |
| dead_i | input | DEAD_W | Dead time in clock counts |
| hs_o | output | 1 | High-side gate command |
| ls_o | output | 1 | Low-side gate command |
| state_o | output | 3 | Current schedule phase |

## Verification
The phase changes on the rising edge that ends the phase's last clock. The scheduled duty moves by one count on the same edge as each ramp step. The gate outputs are a decode of registered state, so they change in the same cycle as the period counter. A new duty or dead time therefore appears only at count 0 of the period after the one in which it was sampled.

The bench reference model steps on every rising edge with these same latencies and compares state and both gates at every falling edge. Period-long pulse-width counts in the reduced phase confirm the clamped target.

// File: rtl/dim_seq_pkg.sv
package dim_seq_pkg;
  typedef enum logic [2:0] {
    ST_DELAY   = 3'd0,
    ST_SOFT    = 3'd1,
    ST_FULL    = 3'd2,
    ST_RAMP    = 3'd3,
    ST_REDUCED = 3'd4
  } dim_state_e;
endpackage

// File: rtl/dim_phase_timer.sv
module dim_phase_timer #(
  parameter int TICK_DIV = 50_000_000,
  parameter int SEC_W    = 16,
  parameter int TICK_W   = $clog2(TICK_DIV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] len_i,
  output logic             done_o
);
  logic [TICK_W-1:0] sub_q;
  logic [SEC_W-1:0]  sec_q;
  logic              tick;

  assign tick   = (sub_q == TICK_W'(TICK_DIV - 1));
  assign done_o = tick && (sec_q == len_i - SEC_W'(1));

  // phase restarts itself on done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (done_o) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (tick) begin
      sub_q <= '0;
      sec_q <= sec_q + SEC_W'(1);
    end else begin
      sub_q <= sub_q + TICK_W'(1);
    end
  end

  p_tick_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= TICK_W'(TICK_DIV - 1));
endmodule

// File: rtl/dim_lin_ramp.sv
module dim_lin_ramp #(
  parameter int TOT_W  = 42,
  parameter int DUTY_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DUTY_W-1:0] span_i,
  input  logic [TOT_W-1:0]  total_i,
  output logic              step_o
);
  // span_i counts spread evenly over total_i clocks, at most one per clock
  logic [TOT_W:0] acc_q, sum, acc_nx;

  assign sum    = acc_q + (TOT_W+1)'(span_i);
  assign step_o = (sum >= {1'b0, total_i});
  assign acc_nx = step_o ? sum - {1'b0, total_i} : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_nx;
  end

  p_acc_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < {1'b0, total_i});
endmodule

// File: rtl/dim_pwm_core.sv
module dim_pwm_core #(
  parameter int PERIOD_CYC = 1515,
  parameter int DUTY_W     = 11,
  parameter int DEAD_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              hs_o,
  output logic              ls_o
);
  localparam int CMP_W = ((DUTY_W > DEAD_W) ? DUTY_W : DEAD_W) + 1;
  localparam logic [DUTY_W-1:0] LAST = DUTY_W'(PERIOD_CYC - 1);

  logic [DUTY_W-1:0] cnt_q, duty_q;
  logic [DEAD_W-1:0] dead_q;
  logic              en_q;
  logic [CMP_W-1:0]  c_x, d_x, t_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
      en_q   <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      duty_q <= duty_i;
      dead_q <= dead_i;
      en_q   <= en_i;
    end else begin
      cnt_q  <= cnt_q + DUTY_W'(1);
    end
  end

  assign c_x  = CMP_W'(cnt_q);
  assign d_x  = CMP_W'(duty_q);
  assign t_x  = CMP_W'(dead_q);
  assign hs_o = en_q && (c_x >= t_x) && (c_x < d_x);
  assign ls_o = en_q && (c_x >= d_x + t_x);

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  p_period_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  p_mid_period_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(duty_q) && $stable(dead_q) && $stable(en_q));
endmodule

// File: rtl/dim_pwm_seq.sv
module dim_pwm_seq
  import dim_seq_pkg::*;
#(
  parameter int PERIOD_CYC = 1515,        // switching period in clocks
  parameter int TICK_DIV   = 50_000_000,  // clocks per second, must be >= PERIOD_CYC/2
  parameter int SEC_W      = 16,
  parameter int DEAD_W     = 6,
  parameter int DELAY_S    = 600,
  parameter int MIN_HOLD_S = 900,
  parameter int MIN_RAMP_S = 90,
  parameter int DUTY_W     = $clog2(PERIOD_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEC_W-1:0]  soft_s_i,
  input  logic [SEC_W-1:0]  hold_s_i,
  input  logic [SEC_W-1:0]  ramp_s_i,
  input  logic [DUTY_W-1:0] red_duty_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              hs_o,
  output logic              ls_o,
  output logic [2:0]        state_o
);
  localparam int    TICK_W       = $clog2(TICK_DIV + 1);
  localparam int    TOT_W        = SEC_W + TICK_W;
  localparam int    HALF         = PERIOD_CYC / 2;
  localparam int    MIN_DUTY     = PERIOD_CYC / 5;
  localparam longint MIN_HOLD_CLK = longint'(MIN_HOLD_S) * longint'(TICK_DIV);
  localparam longint MIN_RAMP_CLK = longint'(MIN_RAMP_S) * longint'(TICK_DIV);

  dim_state_e        state_q, state_nx;
  logic [DUTY_W-1:0] duty_q, red_lo, tgt, span;
  logic [SEC_W-1:0]  soft_len, hold_len, ramp_len, len_sel;
  logic [TOT_W-1:0]  total_soft, total_ramp, total;
  logic              phase_done, step, rising;

  // lamp protection floors
  assign soft_len = (soft_s_i == '0) ? SEC_W'(1) : soft_s_i;
  assign hold_len = (hold_s_i < SEC_W'(MIN_HOLD_S)) ? SEC_W'(MIN_HOLD_S) : hold_s_i;
  assign ramp_len = (ramp_s_i < SEC_W'(MIN_RAMP_S)) ? SEC_W'(MIN_RAMP_S) : ramp_s_i;
  assign red_lo   = (red_duty_i < DUTY_W'(MIN_DUTY)) ? DUTY_W'(MIN_DUTY) : red_duty_i;
  assign tgt      = (red_lo > DUTY_W'(HALF)) ? DUTY_W'(HALF) : red_lo;

  assign total_soft = TOT_W'(soft_len) * TOT_W'(TICK_DIV);
  assign total_ramp = TOT_W'(ramp_len) * TOT_W'(TICK_DIV);
  assign rising     = (state_q == ST_DELAY) || (state_q == ST_SOFT);
  assign span       = rising ? DUTY_W'(HALF) : DUTY_W'(HALF) - tgt;
  assign total      = rising ? total_soft : total_ramp;

  always_comb begin
    len_sel  = SEC_W'(DELAY_S);
    state_nx = state_q;
    unique case (state_q)
      ST_DELAY: begin len_sel = SEC_W'(DELAY_S); state_nx = ST_SOFT;    end
      ST_SOFT:  begin len_sel = soft_len;        state_nx = ST_FULL;    end
      ST_FULL:  begin len_sel = hold_len;        state_nx = ST_RAMP;    end
      ST_RAMP:  begin len_sel = ramp_len;        state_nx = ST_REDUCED; end
      default:  begin len_sel = ramp_len;        state_nx = ST_REDUCED; end
    endcase
  end

  dim_phase_timer #(.TICK_DIV(TICK_DIV), .SEC_W(SEC_W), .TICK_W(TICK_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (len_sel),
    .done_o (phase_done)
  );

  dim_lin_ramp #(.TOT_W(TOT_W), .DUTY_W(DUTY_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (phase_done),
    .span_i  (span),
    .total_i (total),
    .step_o  (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DELAY;
      duty_q  <= '0;
    end else begin
      if (phase_done) state_q <= state_nx;
      if (step && state_q == ST_SOFT)      duty_q <= duty_q + DUTY_W'(1);
      else if (step && state_q == ST_RAMP) duty_q <= duty_q - DUTY_W'(1);
    end
  end

  dim_pwm_core #(.PERIOD_CYC(PERIOD_CYC), .DUTY_W(DUTY_W), .DEAD_W(DEAD_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_DELAY),
    .duty_i (duty_q),
    .dead_i (dead_i),
    .hs_o   (hs_o),
    .ls_o   (ls_o)
  );

  assign state_o = state_q;

  // phase-length counters for the protection checks
  logic [TOT_W-1:0] full_clk_q, ramp_clk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_clk_q <= '0;
      ramp_clk_q <= '0;
    end else begin
      full_clk_q <= (state_q == ST_FULL) ? full_clk_q + TOT_W'(1) : '0;
      ramp_clk_q <= (state_q == ST_RAMP) ? ramp_clk_q + TOT_W'(1) : '0;
    end
  end

  p_delay_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY) |-> !hs_o && !ls_o);
  p_soft_monotone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT) |=> duty_q >= $past(duty_q));
  p_duty_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= DUTY_W'(HALF));
  p_hold_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FULL) |-> duty_q == DUTY_W'(HALF));
  p_warmup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FULL && phase_done) |-> full_clk_q >= TOT_W'(MIN_HOLD_CLK - 1));
  p_ramp_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP && phase_done) |-> ramp_clk_q >= TOT_W'(MIN_RAMP_CLK - 1));
  p_ramp_rate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP) |=> (duty_q <= $past(duty_q)) &&
                             ($past(duty_q) - duty_q <= DUTY_W'(1)));
  p_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REDUCED) |-> duty_q >= DUTY_W'(MIN_DUTY));
  p_no_return_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REDUCED) |=> (state_q == ST_REDUCED) && $stable(duty_q));
  p_code_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);
endmodule

// File: tb/dim_pwm_seq_bench.sv
module dim_pwm_seq_bench;
  localparam int P    = 20;
  localparam int TK   = 10;
  localparam int SW   = 12;
  localparam int DW   = 4;
  localparam int DLY  = 600;
  localparam int MH   = 900;
  localparam int MR   = 90;
  localparam int QW   = $clog2(P + 1);
  localparam int HALF = P / 2;
  localparam int MIND = P / 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] soft_s = '0, hold_s = '0, ramp_s = '0;
  logic [QW-1:0] red_duty = '0;
  logic [DW-1:0] dead = '0;
  logic hs, ls;
  logic [2:0] st;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dim_pwm_seq #(.PERIOD_CYC(P), .TICK_DIV(TK), .SEC_W(SW), .DEAD_W(DW),
                .DELAY_S(DLY), .MIN_HOLD_S(MH), .MIN_RAMP_S(MR)) u_dim_pwm_seq (
    .clk_i(clk), .rst_ni(rst_n), .soft_s_i(soft_s), .hold_s_i(hold_s),
    .ramp_s_i(ramp_s), .red_duty_i(red_duty), .dead_i(dead),
    .hs_o(hs), .ls_o(ls), .state_o(st));

  function automatic int exp_tgt();
    int r = int'(red_duty);
    if (r < MIND) r = MIND;
    if (r > HALF) r = HALF;
    return r;
  endfunction

  function automatic int plen(int s);
    case (s)
      0: return DLY * TK;
      1: return ((soft_s == 0) ? 1 : int'(soft_s)) * TK;
      2: return ((int'(hold_s) < MH) ? MH : int'(hold_s)) * TK;
      default: return ((int'(ramp_s) < MR) ? MR : int'(ramp_s)) * TK;
    endcase
  endfunction

  function automatic int duty_of(int s, int n);
    case (s)
      0: return 0;
      1: return (HALF * n) / plen(1);
      2: return HALF;
      3: return HALF - ((HALF - exp_tgt()) * n) / plen(3);
      default: return exp_tgt();
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R9";
    endcase
  endfunction

  // reference model, one step per rising edge
  int m_st, m_n, m_cnt, m_dq, m_en, m_dead, m_duty;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_n = 0; m_cnt = 0; m_dq = 0; m_en = 0; m_dead = 0; m_duty = 0;
    end else begin
      if (m_cnt == P - 1) begin
        m_dq = m_duty; m_en = (m_st != 0) ? 1 : 0; m_dead = int'(dead);
      end
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
      if (m_st != 4) begin
        if (m_n == plen(m_st) - 1) begin m_st = m_st + 1; m_n = 0; end
        else m_n = m_n + 1;
      end
      m_duty = duty_of(m_st, m_n);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_hs, e_ls;
      e_hs = (m_en != 0 && m_cnt >= m_dead && m_cnt < m_dq) ? 1 : 0;
      e_ls = (m_en != 0 && m_cnt >= m_dq + m_dead) ? 1 : 0;
      n_chk++;
      if (int'(st) != m_st || int'(hs) != e_hs || int'(ls) != e_ls) begin
        n_fail++;
        $display("FAIL %s R3 R4 R10 cnt=%0d state=%0d exp %0d hs=%0d exp %0d ls=%0d exp %0d",
                 tag_of(m_st), m_cnt, st, m_st, hs, e_hs, ls, e_ls);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(int so, int ho, int ra, int rd, int d0, int d1);
    int total, hs_n, ls_n, e_hs, e_ls, first;
    rst_n = 1'b0;
    soft_s = SW'(so); hold_s = SW'(ho); ramp_s = SW'(ra);
    red_duty = QW'(rd); dead = DW'(d0);
    repeat (3) @(negedge clk);
    check(st == 3'd0, "R1 state in reset", int'(st), 0);
    check(!hs && !ls, "R1 gates in reset", int'({hs, ls}), 0);
    rst_n = 1'b1;
    total = plen(0) + plen(1) + plen(2) + plen(3) + 3 * P;
    first = plen(0) + plen(1) + 123;
    repeat (first) @(negedge clk);
    dead = DW'(d1);  // mid-period change, R4
    repeat (total - first) @(negedge clk);
    hs_n = 0; ls_n = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hs_n += int'(hs); ls_n += int'(ls);
    end
    e_hs = (exp_tgt() > d1) ? exp_tgt() - d1 : 0;
    e_ls = (P - exp_tgt() - d1 > 0) ? P - exp_tgt() - d1 : 0;
    check(hs_n == e_hs, "R8 high-side width", hs_n, e_hs);
    check(ls_n == e_ls, "R8 R3 low-side width", ls_n, e_ls);
    check(st == 3'd4, "R9 R10 reduced code", int'(st), 4);
  endtask

  initial begin
    run_case(2, 10, 30, 1, 2, 3);     // hold, ramp and target raised to floors
    run_case(0, 905, 120, 7, 1, 1);   // mid target, longer phases
    run_case(3, 0, 0, 15, 0, 0);      // target capped at half
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule